// File: doc/BRIEF.md
# Steerable Fibonacci Term Generator

This block produces Fibonacci terms from a small clocked datapath. It holds three 16-bit registers: an older term, a newer term and their running total. An adder forms the next total. A mode input chooses where the registers get their next values. In seed mode they take the fixed starting pair 0 and 1. In run mode they take the fed-back terms, so the sequence advances by one term.

The sequence does not advance on its own. Each of the three registers has its own load enable, and an outside controller drives the mode and the enables on every cycle. With one seed cycle and then all enables held high in run mode, the output steps through 1, 2, 3, 5, 8 and onward, one term per clock. Dropping single enables freezes single registers, so a controller can pause the sequence, re-seed it, or run the total against a frozen newer term.

Top module: `fib_seq_gen`

## Requirements
- R1: When `rst` is high at a rising edge, the older, newer and total registers all become 0, so `sum_out` reads 0 after that edge.
- R2: Reset takes priority over every load enable and over the mode input.
- R3: With `run_mode` = 0 (seed) and `ld_total` = 1, the total register loads 1 (that is, 0 + 1).
- R4: With `run_mode` = 0, `ld_older` loads 0 into the older register and `ld_newer` loads 1 into the newer register. The newer value can be seen at the port through the next run-mode total.
- R5: With `run_mode` = 1 (run), the older register loads the previous newer term, the newer register loads the previous total, and the total register loads the previous newer term plus the previous total. All three change on the same edge.
- R6: A register whose load enable is 0 keeps its previous value, whatever the mode.
- R7: The total register loads the sum of the values presented to the older and newer registers, even when those two registers do not load on that edge.
- R8: The adder is 16 bits wide and wraps modulo 2^16, with no flag.
- R9: After one seed cycle with all enables high, run mode with all enables high gives `sum_out` = 2, 3, 5, 8, 13, … on successive edges: F(k+2) after the k-th run edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset, clears all registers |
| run_mode | input | 1 | 0 = load the starting pair, 1 = load the fed-back terms |
| ld_older | input | 1 | Load enable for the older-term register |
| ld_newer | input | 1 | Load enable for the newer-term register |
| ld_total | input | 1 | Load enable for the total register |
| sum_out | output | 16 | Current contents of the total register |

## Verification
Two things can happen on the same edge: a reset and a load with its enable high. A seed and a run step can also reach different registers on the same edge, when the enables are mixed. Random stimulus sets reset together with random enables and modes. It also mixes partial enable patterns in both modes. Each port value is judged against a bench model that applies reset first and then updates each register only under its own enable. Directed runs cover the clean sequence, the case where the total runs against a frozen newer term, and the 16-bit wrap past F(24).

// File: rtl/fib_pkg.sv
package fib_pkg;

    localparam int unsigned FIB_W      = 16;
    localparam int unsigned FIB_NREG   = 3;
    localparam int unsigned IDX_OLDER  = 0;
    localparam int unsigned IDX_NEWER  = 1;
    localparam int unsigned IDX_TOTAL  = 2;

    typedef logic [FIB_W-1:0] term_t;

    typedef enum logic {
        MODE_SEED = 1'b0,
        MODE_RUN  = 1'b1
    } fib_mode_e;

    typedef struct packed {
        term_t older;
        term_t newer;
        term_t total;
    } fib_state_t;

    function automatic term_t wrap_add(input term_t a, input term_t b);
        return a + b;
    endfunction

    function automatic fib_state_t seed_state();
        fib_state_t s;
        s.older = term_t'(0);
        s.newer = term_t'(1);
        s.total = wrap_add(s.older, s.newer);
        return s;
    endfunction

endpackage

// File: rtl/fib_term_reg.sv
module fib_term_reg
    import fib_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  term_t d,
    output term_t q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/fib_next_mux.sv
module fib_next_mux
    import fib_pkg::*;
(
    input  fib_mode_e  mode,
    input  fib_state_t cur,
    output fib_state_t nxt
);

    fib_state_t seed;
    term_t      pre_older;
    term_t      pre_newer;

    always_comb begin
        seed = seed_state();
        if (mode == MODE_RUN) begin
            pre_older = cur.newer;
            pre_newer = cur.total;
        end else begin
            pre_older = seed.older;
            pre_newer = seed.newer;
        end
        nxt.older = pre_older;
        nxt.newer = pre_newer;
        nxt.total = wrap_add(pre_older, pre_newer);
    end

endmodule

// File: rtl/fib_seq_gen.sv
module fib_seq_gen
    import fib_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run_mode,
    input  logic              ld_older,
    input  logic              ld_newer,
    input  logic              ld_total,
    output logic [FIB_W-1:0]  sum_out
);

    fib_mode_e  mode;
    fib_state_t cur_state;
    fib_state_t nxt_state;
    term_t      reg_d  [FIB_NREG];
    term_t      reg_q  [FIB_NREG];
    logic       reg_ld [FIB_NREG];
    term_t      older_q;
    term_t      newer_q;

    assign mode = run_mode ? MODE_RUN : MODE_SEED;

    assign reg_ld[IDX_OLDER] = ld_older;
    assign reg_ld[IDX_NEWER] = ld_newer;
    assign reg_ld[IDX_TOTAL] = ld_total;

    assign reg_d[IDX_OLDER] = nxt_state.older;
    assign reg_d[IDX_NEWER] = nxt_state.newer;
    assign reg_d[IDX_TOTAL] = nxt_state.total;

    always_comb begin
        cur_state.older = reg_q[IDX_OLDER];
        cur_state.newer = reg_q[IDX_NEWER];
        cur_state.total = reg_q[IDX_TOTAL];
    end

    fib_next_mux u_next (
        .mode (mode),
        .cur  (cur_state),
        .nxt  (nxt_state)
    );

    for (genvar i = 0; i < FIB_NREG; i++) begin : g_term
        fib_term_reg u_reg (
            .clk  (clk),
            .rst  (rst),
            .load (reg_ld[i]),
            .d    (reg_d[i]),
            .q    (reg_q[i])
        );
    end

    assign older_q = reg_q[IDX_OLDER];
    assign newer_q = reg_q[IDX_NEWER];
    assign sum_out = reg_q[IDX_TOTAL];

endmodule

// File: rtl/fib_seq_chk.sv
module fib_seq_chk
    import fib_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  run_mode,
    input logic  ld_older,
    input logic  ld_newer,
    input logic  ld_total,
    input term_t sum_out,
    input term_t older_q,
    input term_t newer_q
);

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (sum_out == '0 && older_q == '0 && newer_q == '0)); // R1

    AST_HOLD_TOTAL: assert property (@(posedge clk) disable iff (rst) !ld_total |=> $stable(sum_out)); // R6

    AST_HOLD_NEWER: assert property (@(posedge clk) disable iff (rst) !ld_newer |=> $stable(newer_q)); // R6

    AST_SEED_TOTAL: assert property (@(posedge clk) disable iff (rst) (!run_mode && ld_total) |=> sum_out == term_t'(1)); // R3

    AST_SEED_OLDER: assert property (@(posedge clk) disable iff (rst) (!run_mode && ld_older) |=> older_q == '0); // R4

    AST_SEED_NEWER: assert property (@(posedge clk) disable iff (rst) (!run_mode && ld_newer) |=> newer_q == term_t'(1)); // R4

    AST_RUN_TOTAL: assert property (@(posedge clk) disable iff (rst) (run_mode && ld_total) |=> sum_out == term_t'($past(newer_q) + $past(sum_out))); // R5

    AST_RUN_SHIFT: assert property (@(posedge clk) disable iff (rst) (run_mode && ld_older) |=> older_q == $past(newer_q)); // R5

endmodule

bind fib_seq_gen fib_seq_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .run_mode (run_mode),
    .ld_older (ld_older),
    .ld_newer (ld_newer),
    .ld_total (ld_total),
    .sum_out  (sum_out),
    .older_q  (older_q),
    .newer_q  (newer_q)
);

// File: tb/tb_fib_seq_gen.sv
`timescale 1ns/1ps
module tb_fib_seq_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run_mode = 1'b0;
    logic        ld_older = 1'b0;
    logic        ld_newer = 1'b0;
    logic        ld_total = 1'b0;
    logic [15:0] sum_out;

    int n_vec  = 0;
    int n_fail = 0;

    logic [15:0] m_older = '0;
    logic [15:0] m_newer = '0;
    logic [15:0] m_total = '0;

    always #4 clk = ~clk;

    fib_seq_gen dut (
        .clk      (clk),
        .rst      (rst),
        .run_mode (run_mode),
        .ld_older (ld_older),
        .ld_newer (ld_newer),
        .ld_total (ld_total),
        .sum_out  (sum_out)
    );

    function automatic logic [15:0] fib_term(input int n);
        logic [15:0] a = 16'd0;
        logic [15:0] b = 16'd1;
        logic [15:0] t;
        for (int i = 0; i < n; i++) begin
            t = a + b;
            a = b;
            b = t;
        end
        return a;
    endfunction

    task automatic check(input logic [15:0] exp, input string tag);
        n_vec++;
        if (sum_out !== exp) begin
            n_fail++;
            $display("FAIL %s: sum_out=%0d expected=%0d", tag, sum_out, exp);
        end
    endtask

    task automatic step(input logic r, input logic m, input logic eo, input logic en, input logic es);
        logic [15:0] po, pn, ps;
        logic [16:0] wide;
        string tag;
        rst = r; run_mode = m; ld_older = eo; ld_newer = en; ld_total = es;
        po = m ? m_newer : 16'd0;
        pn = m ? m_total : 16'd1;
        wide = {1'b0, po} + {1'b0, pn};
        ps = wide[15:0];
        if (r)                  tag = (eo || en || es) ? "R2" : "R1";
        else if (!es)           tag = "R6";
        else if (!m)            tag = "R3";
        else if (wide[16])      tag = "R8";
        else if (!en)           tag = "R7";
        else                    tag = "R5";
        @(posedge clk);
        if (r) begin
            m_older = '0; m_newer = '0; m_total = '0;
        end else begin
            if (eo) m_older = po;
            if (en) m_newer = pn;
            if (es) m_total = ps;
        end
        @(negedge clk);
        check(m_total, tag);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: sum_out=%0d expected=finished", sum_out);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rv;
        rv = $urandom(32'h5EED_0F1B);
        @(negedge clk);
        // R1 reset state
        step(1, 0, 0, 0, 0);
        // R2 reset wins over all enables in both modes
        step(1, 1, 1, 1, 1);
        step(1, 0, 1, 1, 1);
        // R3 / R4 seed all registers
        step(0, 0, 1, 1, 1);
        // R9 clean run: F(k+2)
        for (int k = 1; k <= 10; k++) begin
            step(0, 1, 1, 1, 1);
            check(fib_term(k + 2), "R9");
        end
        // R6 hold all registers in run mode
        step(0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        // R4: seed only the newer/older registers, total held, then run total against it
        step(0, 0, 1, 1, 0);
        step(0, 1, 0, 0, 1);
        // R7: total keeps adding the frozen newer term (1)
        step(0, 1, 0, 0, 1);
        step(0, 1, 0, 0, 1);
        // R8: clean run past the 16-bit limit
        step(1, 0, 0, 0, 0);
        step(0, 0, 1, 1, 1);
        for (int k = 1; k <= 26; k++) begin
            step(0, 1, 1, 1, 1);
        end
        check(fib_term(28) , "R8");
        // random mix
        for (int i = 0; i < 400; i++) begin
            rv = $urandom;
            step(rv[3:0] == 4'd0, rv[4], rv[5] | rv[8], rv[6] | rv[9], rv[7] | rv[10]);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule